// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block sits at the receive side of a serial line interface. It takes one received bit per bit clock and searches the stream for the 48-bit SDH/SONET framing pattern. A match locks the byte boundary. The block then deserializes the stream into 8-bit words, or into 4-bit nibbles, and marks the frame boundary with a frame pulse. The parallel clock is a tick, one bit-clock cycle wide, from a divide counter that never stops. A reframe can therefore drop or repeat a word, but it never lengthens or shortens a parallel clock period.

The out-of-frame input is treated as asynchronous and controls the search. A rising edge arms the search. It stays armed until a frame pulse has been produced and the out-of-frame input is low, whichever of the two comes last. While the search is disarmed the boundary is frozen, and only patterns that fall on that boundary produce a pulse. Two signal-detect inputs act together as a polarity-selectable loss-of-signal gate. When they report no signal, the data is replaced with zeros.

Top module: `fa_frame_aligner`

## Requirements
- R1: While reset is low and at the first parallel tick after it, par_dout is 0 and frame_pulse is 0.
- R2: par_tick is high for one bit clock every 8 bit clocks when wide_bus=1, and every 4 when wide_bus=0. The period stays the same while the aligner reframes.
- R3: The framing pattern is three A1 bytes (0xF6) followed directly by three A2 bytes (0x28), compared in the order received. The first bit received is the MSB of each byte.
- R4: frame_pulse is high for exactly one parallel tick period. In 8-bit mode it accompanies par_dout=0x28, the third A2 byte. The next word is the following byte in the new alignment.
- R5: The first received bit of a word appears on par_dout[7] and the last on par_dout[0].
- R6: From the bit clock that drives the first bit of a byte to the sample point after the tick that shows it, 12 to 20 bit clocks pass.
- R7: A rising edge of oof_in arms the search, and an out-of-frame pulse lasting one parallel period is enough. The search stays armed while oof_in is high, and also after oof_in falls if no frame pulse has yet been produced. It disarms once both conditions hold.
- R8: While the search is disarmed, the byte boundary is frozen. A pattern shifted off that boundary produces no pulse and no realignment. A pattern on the boundary still pulses.
- R9: Data passes when sd_pecl differs from sd_ttl (0/1 or 1/0). Data is forced to zero when they are equal (0/0 or 1/1).
- R10: With wide_bus=0, nibbles come out on par_dout[7:4], high nibble first, and par_dout[3:0] is 0. frame_pulse accompanies the nibble 0x8 that completes the third A2.
- R11: par_dout and frame_pulse change only at the edge that starts a par_tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_din | input | 1 | Received serial bit |
| sd_pecl | input | 1 | Signal-detect input A (polarity select) |
| sd_ttl | input | 1 | Signal-detect input B |
| oof_in | input | 1 | Out-of-frame request, asynchronous |
| wide_bus | input | 1 | 1 = 8-bit words, 0 = 4-bit nibbles |
| par_tick | output | 1 | Parallel clock tick, one bit clock wide |
| par_dout | output | 8 | Parallel data, first received bit on bit 7 |
| frame_pulse | output | 1 | Frame boundary marker, one parallel period |

## Verification
The bench places patterns three and five bits away from the current boundary. A frozen boundary that still realigns would pulse on the shifted copy, and an armed search that failed to realign would miss it. It drops out-of-frame before any pattern arrives, and again after the pulse, to separate the "whichever later" rule from a plain level or edge rule. It measures tick spacing across a realignment, which catches a divider that restarts on reframe. It also drives all four signal-detect combinations and both bus widths, which catches a polarity table or nibble order that is inverted.

// File: rtl/fa_pkg.sv
// Shared constants for the frame aligner: word width and framing bytes.
// Assumes the framing pattern is built from equal runs of A1 and A2 bytes.
package fa_pkg;
    localparam int          BYTE_W  = 8;
    localparam int          PHASE_W = $clog2(BYTE_W);
    localparam logic [7:0]  A1_BYTE = 8'hF6;
    localparam logic [7:0]  A2_BYTE = 8'h28;
endpackage

// File: rtl/fa_rx_front.sv
// Receive front end: loss-of-signal gate followed by a retiming pipeline.
// Assumes the two detect inputs are static or change slowly relative to the bit clock.
module fa_rx_front #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_din,
    input  logic sd_pecl,
    input  logic sd_ttl,
    output logic bit_o
);
    logic             sig_ok;
    logic [STAGES-1:0] pipe_q;

    // Detect inputs that differ mean a signal is present.
    assign sig_ok = sd_pecl ^ sd_ttl;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: one retiming flop of the gated bit.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= ser_din & sig_ok;
            end
        end else begin : g_chain
            // Purpose: shift the gated bit through the retiming chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], ser_din & sig_ok};
            end
        end
    endgenerate

    assign bit_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fa_oof_ctrl.sv
// Search arming: synchronizes the out-of-frame request, detects its rising edge,
// and keeps the search armed until a pattern hit has occurred and the request is low.
// Assumes each level of the request lasts at least a few bit clocks.
module fa_oof_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oof_async,
    input  logic hit,
    output logic armed
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   oof_d;
    logic                   hit_seen;
    logic                   oof_s;
    logic                   oof_rise;

    assign oof_s    = sync_q[SYNC_STAGES-1];
    assign oof_rise = oof_s & ~oof_d;

    // Purpose: bring the request into the bit-clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            oof_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], oof_async};
            oof_d  <= oof_s;
        end
    end

    // Purpose: arm on a rising edge, disarm once a hit has been seen and the request is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            hit_seen <= 1'b0;
        end else if (oof_rise) begin
            armed    <= 1'b1;
            hit_seen <= 1'b0;
        end else if (armed) begin
            if (hit)
                hit_seen <= 1'b1;
            if ((hit_seen | hit) & ~oof_s)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/fa_boundary.sv
// Pattern match and boundary tracking. Keeps the last REPEATS*2 bytes in a shift
// register, counts the bit phase within a byte, realigns the phase on an armed match,
// and offers a word (byte or nibble) with its frame flag at each word end.
// Assumes the newest bit enters at the LSB, so the first received bit ends up as the MSB.
module fa_boundary #(
    parameter int REPEATS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_i,
    input  logic                     armed,
    input  logic                     wide,
    output logic                     match_o,
    output logic                     cap_o,
    output logic [fa_pkg::BYTE_W-1:0] cap_data,
    output logic                     cap_frame
);
    import fa_pkg::*;

    localparam int PAT_W = 2 * REPEATS * BYTE_W;
    localparam logic [PAT_W-1:0] PATTERN = {{REPEATS{A1_BYTE}}, {REPEATS{A2_BYTE}}};
    localparam int HALF = BYTE_W / 2;

    logic [PAT_W-1:0]   shift_q;
    logic [PHASE_W-1:0] phase_q;
    logic               byte_end;
    logic               nib_end;
    logic               realign;

    assign match_o  = (shift_q == PATTERN);
    assign realign  = armed & match_o;
    assign byte_end = &phase_q;
    assign nib_end  = &phase_q[PHASE_W-2:0];

    // A word ends at the phase boundary, or immediately on an armed match.
    assign cap_o     = realign | (wide ? byte_end : nib_end);
    assign cap_frame = match_o & (armed | byte_end);
    assign cap_data  = wide ? shift_q[BYTE_W-1:0] : {shift_q[HALF-1:0], {HALF{1'b0}}};

    // Purpose: keep the recent bit history for the pattern compare.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[PAT_W-2:0], bit_i};
    end

    // Purpose: track bit position in the byte, restarting after an armed match.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (realign) phase_q <= '0;
        else              phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/fa_par_out.sv
// Parallel output stage: a free-running word-rate divider that makes the parallel
// tick, a one-word holding register, and the output registers updated on the tick.
// Assumes the divider limit changes only while reset is low.
module fa_par_out (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wide,
    input  logic                     cap,
    input  logic [fa_pkg::BYTE_W-1:0] cap_data,
    input  logic                     cap_frame,
    output logic                     par_tick,
    output logic [fa_pkg::BYTE_W-1:0] par_dout,
    output logic                     frame_pulse
);
    import fa_pkg::*;

    localparam logic [PHASE_W-1:0] LIM_FULL = PHASE_W'(BYTE_W - 1);
    localparam logic [PHASE_W-1:0] LIM_HALF = PHASE_W'(BYTE_W / 2 - 1);

    logic [PHASE_W-1:0] div_q;
    logic [BYTE_W-1:0]  hold_q;
    logic               hold_fp_q;
    logic               hold_new_q;
    logic               tick_edge;

    assign tick_edge = div_q >= (wide ? LIM_FULL : LIM_HALF);
    assign par_tick  = (div_q == '0);

    // Purpose: free-running divider, never restarted by a reframe.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (tick_edge) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Purpose: hold the latest completed word until the next tick takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_fp_q  <= 1'b0;
            hold_new_q <= 1'b0;
        end else if (cap) begin
            hold_q     <= cap_data;
            hold_fp_q  <= cap_frame;
            hold_new_q <= 1'b1;
        end else if (tick_edge) begin
            hold_new_q <= 1'b0;
        end
    end

    // Purpose: update the bus and frame marker once per parallel period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_dout    <= '0;
            frame_pulse <= 1'b0;
        end else if (tick_edge) begin
            par_dout    <= hold_q;
            frame_pulse <= hold_fp_q & hold_new_q;
        end
    end
endmodule

// File: rtl/fa_frame_aligner.sv
// Top level of the frame and byte aligner. Chains the front end, boundary tracker
// and output stage, with the out-of-frame controller arming the search.
// Assumes a single bit clock. The parallel clock is the par_tick enable.
module fa_frame_aligner #(
    parameter int PIPE_STAGES = 3,
    parameter int SYNC_STAGES = 2,
    parameter int REPEATS     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_din,
    input  logic       sd_pecl,
    input  logic       sd_ttl,
    input  logic       oof_in,
    input  logic       wide_bus,
    output logic       par_tick,
    output logic [7:0] par_dout,
    output logic       frame_pulse
);
    import fa_pkg::*;

    logic              rx_bit;
    logic              armed;
    logic              match;
    logic              cap;
    logic [BYTE_W-1:0] cap_data;
    logic              cap_frame;

    fa_rx_front #(.STAGES(PIPE_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din),
        .sd_pecl(sd_pecl), .sd_ttl(sd_ttl), .bit_o(rx_bit)
    );

    fa_oof_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_oof (
        .clk(clk), .rst_n(rst_n), .oof_async(oof_in),
        .hit(match), .armed(armed)
    );

    fa_boundary #(.REPEATS(REPEATS)) u_bnd (
        .clk(clk), .rst_n(rst_n), .bit_i(rx_bit), .armed(armed),
        .wide(wide_bus), .match_o(match), .cap_o(cap),
        .cap_data(cap_data), .cap_frame(cap_frame)
    );

    fa_par_out u_out (
        .clk(clk), .rst_n(rst_n), .wide(wide_bus), .cap(cap),
        .cap_data(cap_data), .cap_frame(cap_frame),
        .par_tick(par_tick), .par_dout(par_dout), .frame_pulse(frame_pulse)
    );
endmodule

// File: rtl/fa_frame_aligner_chk.sv
// Property checker for the frame aligner, attached by bind.
// Assumes wide_bus changes only while reset is low.
module fa_frame_aligner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sd_pecl,
    input logic       sd_ttl,
    input logic       wide_bus,
    input logic       par_tick,
    input logic [7:0] par_dout,
    input logic       frame_pulse
);
    logic [7:0] gap_q;
    logic       seen_q;
    logic       prev_fp_q;
    logic [5:0] sq_q;

    // Purpose: measure bit clocks since the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (par_tick) begin
            gap_q  <= 8'd1;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 8'd1;
        end
    end

    // Purpose: remember the frame marker seen at the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_fp_q <= 1'b0;
        else if (par_tick) prev_fp_q <= frame_pulse;
    end

    // Purpose: count consecutive bit clocks without a signal.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sq_q <= '0;
        else if (sd_pecl != sd_ttl)  sq_q <= '0;
        else if (sq_q != 6'd63)      sq_q <= sq_q + 6'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (par_dout == 8'h00 && !frame_pulse));

    assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (par_tick && seen_q) |-> (gap_q == (wide_bus ? 8'd8 : 8'd4)));

    assert_pulse_on_a2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && par_tick && wide_bus) |-> (par_dout == fa_pkg::A2_BYTE));

    assert_pulse_one_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_tick && frame_pulse) |-> !prev_fp_q);

    assert_squelch_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_tick && sq_q >= 6'd24) |-> (par_dout == 8'h00));

    assert_nibble_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_bus |-> (par_dout[3:0] == 4'h0));

    assert_change_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !par_tick |-> ($stable(par_dout) && $stable(frame_pulse)));
endmodule

bind fa_frame_aligner fa_frame_aligner_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sd_pecl(sd_pecl), .sd_ttl(sd_ttl),
    .wide_bus(wide_bus), .par_tick(par_tick), .par_dout(par_dout),
    .frame_pulse(frame_pulse)
);

// File: tb/fa_frame_aligner_bench.sv
module fa_frame_aligner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_din = 1'b0;
    logic       sd_pecl = 1'b0;
    logic       sd_ttl = 1'b1;
    logic       oof_in = 1'b0;
    logic       wide_bus = 1'b1;
    logic       par_tick;
    logic [7:0] par_dout;
    logic       frame_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0] log_d [0:4095];
    logic       log_f [0:4095];
    int         log_c [0:4095];
    int         nlog = 0;

    fa_frame_aligner u_fa_frame_aligner (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .sd_pecl(sd_pecl),
        .sd_ttl(sd_ttl), .oof_in(oof_in), .wide_bus(wide_bus),
        .par_tick(par_tick), .par_dout(par_dout), .frame_pulse(frame_pulse)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record every parallel word mid-cycle.
    always @(negedge clk) begin
        if (rst_n && par_tick && nlog < 4096) begin
            log_d[nlog] = par_dout;
            log_f[nlog] = frame_pulse;
            log_c[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_din = b;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_byte_t(input logic [7:0] v, output int t);
        @(negedge clk);
        ser_din = v[7];
        t = cyc;
        for (int i = 6; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_zero_bits(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic send_zero_bytes(input int n);
        for (int i = 0; i < n; i++) send_byte(8'h00);
    endtask

    task automatic send_frame();
        for (int i = 0; i < 3; i++) send_byte(8'hF6);
        for (int i = 0; i < 3; i++) send_byte(8'h28);
    endtask

    function automatic int find_fp(input int from);
        for (int i = from; i < nlog; i++) if (log_f[i]) return i;
        return -1;
    endfunction

    function automatic int count_fp(input int from);
        int n = 0;
        for (int i = from; i < nlog; i++) if (log_f[i]) n++;
        return n;
    endfunction

    task automatic do_reset(input logic wide);
        @(negedge clk);
        rst_n = 1'b0; oof_in = 1'b0; ser_din = 1'b0;
        sd_pecl = 1'b0; sd_ttl = 1'b1; wide_bus = wide;
        repeat (5) @(negedge clk);
        chk(par_dout == 8'h00 && !frame_pulse, "R1 reset outputs", par_dout, 0);
        rst_n = 1'b1;
    endtask

    // R1: outputs clear at the first tick after reset.
    task automatic t_reset();
        int s;
        do_reset(1'b1);
        s = nlog;
        send_zero_bytes(2);
        chk(nlog > s && log_d[s] == 8'h00 && !log_f[s], "R1 first tick", log_d[s], 0);
    endtask

    // R3 R4 R5 R6 R2 R7: armed acquisition at an arbitrary offset.
    task automatic t_acquire();
        int s, f, t0, d;
        oof_in = 1'b1;
        s = nlog;
        send_zero_bytes(4);
        send_zero_bits(3);
        send_frame();
        send_byte_t(8'h11, t0);
        send_byte(8'h5A);
        send_zero_bytes(4);
        f = find_fp(s);
        chk(f >= 0, "R3 pattern found", f, 1);
        if (f >= 0) begin
            chk(log_d[f] == 8'h28, "R4 pulse on third A2", log_d[f], 8'h28);
            chk(log_d[f+1] == 8'h11, "R4 next byte new alignment", log_d[f+1], 8'h11);
            chk(!log_f[f+1], "R4 pulse one period", log_f[f+1], 0);
            chk(log_d[f+2] == 8'h5A, "R5 bit order", log_d[f+2], 8'h5A);
            d = log_c[f+1] - t0;
            chk(d >= 12 && d <= 20, "R6 latency", d, 16);
        end
        chk(count_fp(s) == 1, "R4 single pulse", count_fp(s), 1);
        for (int i = s + 1; i < nlog; i++)
            chk(log_c[i] - log_c[i-1] == 8, "R2 period 8 through reframe",
                log_c[i] - log_c[i-1], 8);
        // Still armed while oof high: a shifted pattern realigns.
        s = nlog;
        send_zero_bits(5);
        send_frame();
        send_byte(8'h3C);
        send_zero_bytes(4);
        f = find_fp(s);
        chk(f >= 0 && log_d[f+1] == 8'h3C, "R7 armed while oof high",
            (f >= 0) ? log_d[f+1] : -1, 8'h3C);
    endtask

    // R8: disarmed, boundary frozen.
    task automatic t_frozen();
        int s, f;
        oof_in = 1'b0;
        send_zero_bytes(2);
        s = nlog;
        send_zero_bits(3);
        send_frame();
        send_zero_bytes(4);
        chk(count_fp(s) == 0, "R8 off-boundary ignored", count_fp(s), 0);
        s = nlog;
        send_zero_bits(5);
        send_frame();
        send_byte(8'h77);
        send_zero_bytes(4);
        f = find_fp(s);
        chk(f >= 0 && log_d[f] == 8'h28 && log_d[f+1] == 8'h77, "R8 on-boundary pulses",
            (f >= 0) ? log_d[f+1] : -1, 8'h77);
    endtask

    // R7: short oof pulse, pattern arrives later; then disarms.
    task automatic t_short_oof();
        int s, f;
        oof_in = 1'b1;
        send_byte(8'h00);
        oof_in = 1'b0;
        send_zero_bytes(2);
        s = nlog;
        send_zero_bits(3);
        send_frame();
        send_byte(8'h42);
        send_zero_bytes(4);
        f = find_fp(s);
        chk(f >= 0 && log_d[f+1] == 8'h42, "R7 short oof held armed",
            (f >= 0) ? log_d[f+1] : -1, 8'h42);
        s = nlog;
        send_zero_bits(3);
        send_frame();
        send_zero_bytes(4);
        chk(count_fp(s) == 0, "R7 disarmed after pulse and low", count_fp(s), 0);
        send_zero_bits(5);
    endtask

    // R9: signal-detect truth table.
    task automatic t_sigdet();
        logic [1:0] combos [0:3];
        logic [7:0] expv;
        combos[0] = 2'b01; combos[1] = 2'b10; combos[2] = 2'b00; combos[3] = 2'b11;
        for (int k = 0; k < 4; k++) begin
            sd_pecl = combos[k][1];
            sd_ttl  = combos[k][0];
            send_byte(8'hA5); send_byte(8'hA5); send_byte(8'hA5);
            send_byte(8'hA5); send_byte(8'hA5);
            expv = (combos[k][1] != combos[k][0]) ? 8'hA5 : 8'h00;
            chk(log_d[nlog-1] == expv, "R9 signal detect", log_d[nlog-1], expv);
        end
        sd_pecl = 1'b0; sd_ttl = 1'b1;
    endtask

    // R10 R2: nibble mode.
    task automatic t_nibble();
        int s, f;
        do_reset(1'b0);
        s = nlog;
        send_zero_bytes(3);
        for (int i = s + 1; i < nlog; i++)
            chk(log_c[i] - log_c[i-1] == 4, "R2 period 4", log_c[i] - log_c[i-1], 4);
        oof_in = 1'b1;
        s = nlog;
        send_zero_bits(1);
        send_frame();
        send_byte(8'h3C);
        send_zero_bytes(4);
        f = find_fp(s);
        chk(f >= 0, "R10 nibble pattern found", f, 1);
        if (f >= 0) begin
            chk(log_d[f] == 8'h80, "R10 pulse nibble", log_d[f], 8'h80);
            chk(log_d[f+1] == 8'h30, "R10 high nibble first", log_d[f+1], 8'h30);
            chk(log_d[f+2] == 8'hC0, "R10 low nibble", log_d[f+2], 8'hC0);
        end
        chk(count_fp(s) == 1, "R10 single pulse", count_fp(s), 1);
        oof_in = 1'b0;
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_frozen();
        t_short_oof();
        t_sigdet();
        t_nibble();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule